// File: doc/BRIEF.md
# Operand Bypass and Load-Use Interlock Control

This block is the hazard-control logic of a five-stage in-order integer pipeline whose stages are fetch, decode with register read, execute, memory access and write-back. It is purely combinational. From the register numbers that the instructions in the execute and decode stages read, and from the destination numbers and control flags that travel with the instructions further down the pipe, it decides where each of the two ALU operands should come from. It also decides whether the pipeline must hold for one cycle because a load result is needed too early.

An ALU operand takes a freshly computed result from the execute/memory pipeline register or from the memory/write-back pipeline register as soon as that result exists, without waiting for the register-file write. The register file writes in the first half of the cycle and reads in the second, so a value that write-back is committing is already visible to decode, and no bypass path beyond write-back is needed. If the instruction in decode reads the destination of a load that is in execute, bypassing is not enough. The unit then raises a stall, which freezes the PC and the fetch/decode register so that both front stages repeat their work. It raises a bubble at the same time, which clears the control bits entering execute so that the held slot behaves as a nop. One cycle later the load sits in write-back and its data reaches the dependent instruction through the memory/write-back bypass.

Top module: `hz_ctrl_unit`

## Requirements
- R1: An operand select is 2'b10 (execute/memory result) when that stage writes a register (`mem_wen`=1), is not a load, has a nonzero destination, and that destination equals the operand's source number.
- R2: An operand select is 2'b01 (memory/write-back result) when write-back writes a nonzero destination equal to the operand's source and the execute/memory stage does not qualify under R1.
- R3: When both later stages qualify for the same operand, the select is 2'b10, so the younger result wins.
- R4: Register 0 is never bypassed and never causes a stall: a source or destination number of 0 gives select 2'b00 and no stall from that match.
- R5: A stage whose write-enable is 0 is never a bypass source and a load in execute with write-enable 0 never stalls.
- R6: `stall` is 1 exactly when execute holds a load (`ex_is_load`=1, `ex_wen`=1) with a nonzero destination equal to either decode source number.
- R7: `bubble` is 1 in exactly the same cycles as `stall`.
- R8: With no qualifying match, an operand select is 2'b00 (register-file value); the code 2'b11 never appears.
- R9: A load in the memory stage (`mem_is_load`=1) is never taken from the execute/memory register, because its data does not exist yet; the select falls through to R2 or R8.
- R10: Operand A and operand B are selected independently, each from its own source number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_src_a | input | 5 | Source register of ALU operand A, instruction in execute |
| ex_src_b | input | 5 | Source register of ALU operand B, instruction in execute |
| id_src_a | input | 5 | First source register of the instruction in decode |
| id_src_b | input | 5 | Second source register of the instruction in decode |
| ex_dst | input | 5 | Destination register of the instruction in execute |
| ex_wen | input | 1 | Instruction in execute writes a register |
| ex_is_load | input | 1 | Instruction in execute is a load |
| mem_dst | input | 5 | Destination register held in the execute/memory register |
| mem_wen | input | 1 | Instruction in memory stage writes a register |
| mem_is_load | input | 1 | Instruction in memory stage is a load |
| wb_dst | input | 5 | Destination register held in the memory/write-back register |
| wb_wen | input | 1 | Instruction in write-back writes a register |
| op_a_sel | output | 2 | Operand A source: 00 register file, 10 execute/memory, 01 memory/write-back |
| op_b_sel | output | 2 | Operand B source, same encoding |
| stall | output | 1 | Hold the PC and the fetch/decode register this cycle |
| bubble | output | 1 | Clear the control bits entering execute this cycle |

## Verification
Because the unit has no state, a wrong comparison or priority shows at the select or stall outputs in the same cycle as the offending input pattern, and in a real pipeline it would corrupt the very next ALU result. The directed scenarios therefore set each pattern and read the outputs before the next one: single and double matches, register 0, disabled writes, a load in memory, and a load in execute against each decode source. A missed stall would show as `stall` and `bubble` low where a load-use pair is present, and a spurious one would show them high for a pair that bypassing already covers.

// File: rtl/hz_pkg.sv
package hz_pkg;

  typedef enum logic [1:0] {
    SEL_RF  = 2'b00,
    SEL_WB  = 2'b01,
    SEL_MEM = 2'b10
  } fwd_sel_e;

endpackage

// File: rtl/hz_fwd_select.sv
module hz_fwd_select
  import hz_pkg::*;
#(
  parameter int REG_AW = 5
) (
  input  logic [REG_AW-1:0] src,
  input  logic [REG_AW-1:0] mem_dst,
  input  logic              mem_wen,
  input  logic              mem_is_load,
  input  logic [REG_AW-1:0] wb_dst,
  input  logic              wb_wen,
  output fwd_sel_e          sel
);

  localparam logic [REG_AW-1:0] ZERO_REG = '0;

  logic mem_hit;
  logic wb_hit;

  // A producer qualifies only if it writes, is not register 0 and matches.
  always_comb begin
    mem_hit = mem_wen && !mem_is_load && (mem_dst != ZERO_REG) && (mem_dst == src);
    wb_hit  = wb_wen && (wb_dst != ZERO_REG) && (wb_dst == src);
  end

  // Younger producer is checked first.
  always_comb begin
    if (mem_hit)     sel = SEL_MEM;
    else if (wb_hit) sel = SEL_WB;
    else             sel = SEL_RF;
  end

  always_comb begin
    if (!$isunknown({src, mem_dst, mem_wen, mem_is_load, wb_dst, wb_wen})) begin
      AST_ZERO_SRC_FROM_RF: assert (src != ZERO_REG || sel == SEL_RF) else $error("r0 bypassed"); // R4
      AST_LOAD_NOT_FROM_MEM: assert (!mem_is_load || sel != SEL_MEM) else $error("load data taken early"); // R9
      AST_SEL_CODE_LEGAL: assert (sel != 2'b11) else $error("illegal select code"); // R8
    end
  end

endmodule

// File: rtl/hz_load_interlock.sv
module hz_load_interlock #(
  parameter int REG_AW  = 5,
  parameter int NUM_SRC = 2
) (
  input  logic [NUM_SRC-1:0][REG_AW-1:0] id_src,
  input  logic [REG_AW-1:0]              ex_dst,
  input  logic                           ex_wen,
  input  logic                           ex_is_load,
  output logic                           stall
);

  localparam logic [REG_AW-1:0] ZERO_REG = '0;

  logic              load_live;
  logic [NUM_SRC-1:0] src_dep;

  always_comb load_live = ex_is_load && ex_wen && (ex_dst != ZERO_REG);

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_dep
    always_comb src_dep[g] = load_live && (id_src[g] == ex_dst);
  end

  always_comb stall = |src_dep;

  always_comb begin
    if (!$isunknown({id_src, ex_dst, ex_wen, ex_is_load})) begin
      AST_STALL_NEEDS_LOAD: assert (!stall || (ex_is_load && ex_wen)) else $error("stall without load"); // R5
      AST_STALL_NOT_ON_R0: assert (!stall || ex_dst != ZERO_REG) else $error("stall on r0"); // R4
    end
  end

endmodule

// File: rtl/hz_ctrl_unit.sv
module hz_ctrl_unit
  import hz_pkg::*;
#(
  parameter int REG_AW = 5
) (
  input  logic [REG_AW-1:0] ex_src_a,
  input  logic [REG_AW-1:0] ex_src_b,
  input  logic [REG_AW-1:0] id_src_a,
  input  logic [REG_AW-1:0] id_src_b,
  input  logic [REG_AW-1:0] ex_dst,
  input  logic              ex_wen,
  input  logic              ex_is_load,
  input  logic [REG_AW-1:0] mem_dst,
  input  logic              mem_wen,
  input  logic              mem_is_load,
  input  logic [REG_AW-1:0] wb_dst,
  input  logic              wb_wen,
  output logic [1:0]        op_a_sel,
  output logic [1:0]        op_b_sel,
  output logic              stall,
  output logic              bubble
);

  localparam int NUM_OPS = 2;

  logic [NUM_OPS-1:0][REG_AW-1:0] ex_src;
  logic [NUM_OPS-1:0][REG_AW-1:0] id_src;
  fwd_sel_e [NUM_OPS-1:0]         op_sel;
  logic                           hold;

  always_comb begin
    ex_src[0] = ex_src_a;
    ex_src[1] = ex_src_b;
    id_src[0] = id_src_a;
    id_src[1] = id_src_b;
  end

  for (genvar g = 0; g < NUM_OPS; g++) begin : g_op
    hz_fwd_select #(.REG_AW(REG_AW)) u_sel (
      .src         (ex_src[g]),
      .mem_dst     (mem_dst),
      .mem_wen     (mem_wen),
      .mem_is_load (mem_is_load),
      .wb_dst      (wb_dst),
      .wb_wen      (wb_wen),
      .sel         (op_sel[g])
    );
  end

  hz_load_interlock #(.REG_AW(REG_AW), .NUM_SRC(NUM_OPS)) u_ilk (
    .id_src     (id_src),
    .ex_dst     (ex_dst),
    .ex_wen     (ex_wen),
    .ex_is_load (ex_is_load),
    .stall      (hold)
  );

  always_comb begin
    op_a_sel = op_sel[0];
    op_b_sel = op_sel[1];
    stall    = hold;
    bubble   = hold;
  end

  always_comb begin
    if (!$isunknown({ex_src_a, ex_src_b, id_src_a, id_src_b, ex_dst, ex_wen, ex_is_load,
                     mem_dst, mem_wen, mem_is_load, wb_dst, wb_wen})) begin
      AST_BUBBLE_WITH_STALL: assert (bubble == stall) else $error("bubble/stall mismatch"); // R7
      AST_NO_WRITER_NO_FWD: assert (mem_wen || wb_wen || (op_a_sel == 2'b00 && op_b_sel == 2'b00))
        else $error("bypass with no writer"); // R5
      AST_NO_LOAD_NO_STALL: assert (ex_is_load || !stall) else $error("stall without load in EX"); // R6
    end
  end

endmodule

// File: tb/sim_hz_ctrl_unit.sv
module sim_hz_ctrl_unit;

  logic       clk = 1'b0;
  logic [4:0] ex_src_a, ex_src_b, id_src_a, id_src_b, ex_dst, mem_dst, wb_dst;
  logic       ex_wen, ex_is_load, mem_wen, mem_is_load, wb_wen;
  logic [1:0] op_a_sel, op_b_sel;
  logic       stall, bubble;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  hz_ctrl_unit u0 (
    .ex_src_a(ex_src_a), .ex_src_b(ex_src_b), .id_src_a(id_src_a), .id_src_b(id_src_b),
    .ex_dst(ex_dst), .ex_wen(ex_wen), .ex_is_load(ex_is_load),
    .mem_dst(mem_dst), .mem_wen(mem_wen), .mem_is_load(mem_is_load),
    .wb_dst(wb_dst), .wb_wen(wb_wen),
    .op_a_sel(op_a_sel), .op_b_sel(op_b_sel), .stall(stall), .bubble(bubble)
  );

  task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic clear_all();
    @(posedge clk);
    ex_src_a = 0; ex_src_b = 0; id_src_a = 0; id_src_b = 0;
    ex_dst = 0; ex_wen = 0; ex_is_load = 0;
    mem_dst = 0; mem_wen = 0; mem_is_load = 0;
    wb_dst = 0; wb_wen = 0;
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  task automatic t_idle();
    clear_all(); settle();
    check("R8 idle A", op_a_sel, 2'b00);
    check("R8 idle B", op_b_sel, 2'b00);
    check("R6 idle stall", {1'b0, stall}, 2'b00);
    check("R7 idle bubble", {1'b0, bubble}, 2'b00);
  endtask

  task automatic t_mem_fwd();
    clear_all();
    ex_src_a = 5'd7; ex_src_b = 5'd3; mem_dst = 5'd7; mem_wen = 1; settle();
    check("R1 mem fwd A", op_a_sel, 2'b10);
    check("R10 B untouched", op_b_sel, 2'b00);
  endtask

  task automatic t_wb_fwd();
    clear_all();
    ex_src_a = 5'd2; ex_src_b = 5'd9; wb_dst = 5'd9; wb_wen = 1; settle();
    check("R2 wb fwd B", op_b_sel, 2'b01);
    check("R10 A untouched", op_a_sel, 2'b00);
  endtask

  task automatic t_priority();
    clear_all();
    ex_src_a = 5'd12; ex_src_b = 5'd12; mem_dst = 5'd12; mem_wen = 1; wb_dst = 5'd12; wb_wen = 1; settle();
    check("R3 priority A", op_a_sel, 2'b10);
    check("R3 priority B", op_b_sel, 2'b10);
  endtask

  task automatic t_split();
    clear_all();
    ex_src_a = 5'd4; ex_src_b = 5'd5; mem_dst = 5'd5; mem_wen = 1; wb_dst = 5'd4; wb_wen = 1; settle();
    check("R10 split A", op_a_sel, 2'b01);
    check("R10 split B", op_b_sel, 2'b10);
  endtask

  task automatic t_zero_reg();
    clear_all();
    mem_wen = 1; wb_wen = 1; ex_wen = 1; ex_is_load = 1; settle();
    check("R4 r0 A", op_a_sel, 2'b00);
    check("R4 r0 B", op_b_sel, 2'b00);
    check("R4 r0 stall", {1'b0, stall}, 2'b00);
  endtask

  task automatic t_no_wen();
    clear_all();
    ex_src_a = 5'd6; ex_src_b = 5'd6; mem_dst = 5'd6; wb_dst = 5'd6;
    id_src_a = 5'd6; ex_dst = 5'd6; ex_is_load = 1; settle();
    check("R5 no wen A", op_a_sel, 2'b00);
    check("R5 no wen B", op_b_sel, 2'b00);
    check("R5 no wen stall", {1'b0, stall}, 2'b00);
  endtask

  task automatic t_mem_load();
    clear_all();
    ex_src_a = 5'd8; ex_src_b = 5'd8; mem_dst = 5'd8; mem_wen = 1; mem_is_load = 1; settle();
    check("R9 load in mem A", op_a_sel, 2'b00);
    wb_dst = 5'd8; wb_wen = 1; settle();
    check("R9 load in mem falls to wb", op_b_sel, 2'b01);
  endtask

  task automatic t_load_use();
    clear_all();
    ex_dst = 5'd10; ex_wen = 1; ex_is_load = 1; id_src_a = 5'd10; id_src_b = 5'd1; settle();
    check("R6 stall on src A", {1'b0, stall}, 2'b01);
    check("R7 bubble on src A", {1'b0, bubble}, 2'b01);
    id_src_a = 5'd1; id_src_b = 5'd10; settle();
    check("R6 stall on src B", {1'b0, stall}, 2'b01);
    id_src_b = 5'd11; settle();
    check("R6 no dep no stall", {1'b0, stall}, 2'b00);
    check("R7 no dep no bubble", {1'b0, bubble}, 2'b00);
    ex_is_load = 0; id_src_a = 5'd10; settle();
    check("R6 alu op no stall", {1'b0, stall}, 2'b00);
  endtask

  task automatic t_after_stall();
    // Cycle after the interlock: load now in write-back, consumer in execute.
    clear_all();
    ex_src_a = 5'd10; wb_dst = 5'd10; wb_wen = 1; settle();
    check("R2 load data from wb", op_a_sel, 2'b01);
    check("R6 no repeat stall", {1'b0, stall}, 2'b00);
  endtask

  initial begin
    t_idle();
    t_mem_fwd();
    t_wb_fwd();
    t_priority();
    t_split();
    t_zero_reg();
    t_no_wen();
    t_mem_load();
    t_load_use();
    t_after_stall();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule